// File: doc/BRIEF.md
# SGI Target Range Decoder

This block sits on the receive side of a per-core interrupt redistributor and decides whether an incoming software-generated-interrupt request is meant for the local core. Each request is a 64-bit word that arrives with a one-cycle valid strobe. The block unpacks the word's affinity fields, its routing mode, its 16-bit target list and its 4-bit range selector. It then compares them with the core's own affinity. When the core is addressed, it raises a registered one-cycle pending pulse that carries the 4-bit interrupt ID.

The range selector picks which group of sixteen level-0 affinity values the target list covers, so a single cluster can hold up to 256 cores. Two capability inputs gate its use: one for the CPU interface and one for the distributor. A build-time parameter decides what happens when only the CPU interface supports range selection: the request is either dropped or its selector is forced to zero. A broadcast routing mode reaches every core except the one that sent the request.

Top module: `sgi_target_decoder`

## Requirements
- R1: Request word layout: target list [15:0], affinity-1 [23:16], interrupt ID [27:24], affinity-2 [39:32], routing mode [40], range selector [47:44], affinity-3 [55:48]. Core and source affinities are packed as affinity-3 [31:24], affinity-2 [23:16], affinity-1 [15:8], affinity-0 [7:0].
- R2: In directed mode (bit 40 = 0), a request hits when all of the following hold:
  - affinity-3, affinity-2 and affinity-1 equal the core's values;
  - core affinity-0 bits [7:4] equal the effective selector;
  - the target-list bit indexed by core affinity-0 bits [3:0] is 1.
  On a hit, `pend_pulse` is 1 in the cycle after `req_valid`, and `pend_id` equals the request's ID.
- R3: In directed mode, a mismatch in any of affinity-3, affinity-2 or affinity-1 produces no pulse.
- R4: When `cpuif_rss` is 0, the selector field is treated as 0. A core whose affinity-0 is 16 or more is then never hit in directed mode.
- R5: When both `cpuif_rss` and `dist_rss` are 1, target-list bit n addresses affinity-0 equal to selector*16 + n.
- R6: When `cpuif_rss` is 1, `dist_rss` is 0 and the selector is nonzero, a directed request behaves according to `DROP_ON_RS_CONFLICT`:
  - when the parameter is 1 (the default), the request is dropped;
  - when the parameter is 0, the selector is treated as 0.
- R7: In broadcast mode (bit 40 = 1), the affinity fields, target list and selector are ignored. Every core hits except the one whose `core_aff` equals `src_aff`.
- R8: `pend_pulse` lasts one cycle per accepted request and is never 1 in a cycle that does not follow a valid strobe. Reset clears `pend_pulse` and `pend_id` to 0.
- R9: `cpuif_ctl_status` carries `cpuif_rss` at bit 18, and `dist_type_status` carries `dist_rss` at bit 26. All other bits of both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_word | input | 64 | SGI request word |
| core_aff | input | 32 | Affinity of this core |
| src_aff | input | 32 | Affinity of the requesting core |
| cpuif_rss | input | 1 | Range-selector support at the CPU interface |
| dist_rss | input | 1 | Range-selector support at the distributor |
| pend_pulse | output | 1 | One-cycle pending pulse |
| pend_id | output | 4 | Interrupt ID of the last hit |
| cpuif_ctl_status | output | 32 | Read-only CPU-interface control view |
| dist_type_status | output | 32 | Read-only distributor type view |

## Verification
The hardest case to reach from the ports is the capability mismatch: the CPU interface supports range selection, the distributor does not, and a nonzero selector arrives. The two parameter choices must diverge exactly there. The bench drives identical stimulus into two instances, one built to drop and one built to force the selector to zero. It places the core at affinity-0 values both inside and outside group 0, so the pair disagrees only where R6 says it should. Broadcast requests are sent with deliberately mismatched affinities and an empty target list, so that only the originator check can suppress the pulse.

// File: rtl/sgi_rx_pkg.sv
package sgi_rx_pkg;

    localparam int AFF_W    = 8;
    localparam int TLIST_W  = 16;
    localparam int RS_W     = 4;
    localparam int ID_W     = 4;
    localparam int WORD_W   = 64;
    localparam int CORE_W   = 4 * AFF_W;
    localparam int STATUS_W = 32;
    localparam int LANE_W   = $clog2(TLIST_W);

    // bit positions inside the request word
    localparam int TLIST_LSB = 0;
    localparam int AFF1_LSB  = 16;
    localparam int ID_LSB    = 24;
    localparam int AFF2_LSB  = 32;
    localparam int MODE_BIT  = 40;
    localparam int RS_LSB    = 44;
    localparam int AFF3_LSB  = 48;

    // status bit positions
    localparam int CPUIF_RSS_BIT = 18;
    localparam int DIST_RSS_BIT  = 26;

    typedef struct packed {
        logic [AFF_W-1:0]   aff3;
        logic [RS_W-1:0]    rs;
        logic               bcast;
        logic [AFF_W-1:0]   aff2;
        logic [ID_W-1:0]    id;
        logic [AFF_W-1:0]   aff1;
        logic [TLIST_W-1:0] tlist;
    } sgi_req_t;

    typedef struct packed {
        logic [AFF_W-1:0] a3;
        logic [AFF_W-1:0] a2;
        logic [AFF_W-1:0] a1;
        logic [AFF_W-1:0] a0;
    } core_aff_t;

    function automatic sgi_req_t unpack_req(input logic [WORD_W-1:0] w);
        sgi_req_t r;
        r.tlist = w[TLIST_LSB +: TLIST_W];
        r.aff1  = w[AFF1_LSB  +: AFF_W];
        r.id    = w[ID_LSB    +: ID_W];
        r.aff2  = w[AFF2_LSB  +: AFF_W];
        r.bcast = w[MODE_BIT];
        r.rs    = w[RS_LSB    +: RS_W];
        r.aff3  = w[AFF3_LSB  +: AFF_W];
        return r;
    endfunction

    function automatic logic [STATUS_W-1:0] status_word(input logic flag, input int pos);
        logic [STATUS_W-1:0] s;
        s = '0;
        s[pos] = flag;
        return s;
    endfunction

endpackage

// File: rtl/sgi_field_extract.sv
module sgi_field_extract
    import sgi_rx_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output sgi_req_t          req_o
);
    // pure wiring: fields are pulled out of their fixed slots
    always_comb begin
        req_o = unpack_req(word_i);
    end
endmodule

// File: rtl/sgi_rs_resolve.sv
module sgi_rs_resolve
    import sgi_rx_pkg::*;
#(
    parameter bit DROP_ON_RS_CONFLICT = 1'b1
) (
    input  logic            cpuif_rss_i,
    input  logic            dist_rss_i,
    input  logic [RS_W-1:0] rs_field_i,
    output logic [RS_W-1:0] eff_rs_o,
    output logic            drop_o
);
    logic conflict;

    always_comb begin
        conflict = cpuif_rss_i && !dist_rss_i && (rs_field_i != '0);
    end

    generate
        if (DROP_ON_RS_CONFLICT) begin : g_drop
            always_comb begin
                drop_o   = conflict;
                eff_rs_o = cpuif_rss_i ? rs_field_i : '0;
            end
        end else begin : g_force
            always_comb begin
                drop_o   = 1'b0;
                eff_rs_o = (cpuif_rss_i && dist_rss_i) ? rs_field_i : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/sgi_target_match.sv
module sgi_target_match
    import sgi_rx_pkg::*;
(
    input  sgi_req_t         req_i,
    input  logic [RS_W-1:0]  eff_rs_i,
    input  logic             drop_i,
    input  core_aff_t        core_i,
    input  core_aff_t        src_i,
    output logic             hit_o
);
    logic [TLIST_W-1:0] lane_sel;
    logic               upper_eq;
    logic               group_eq;
    logic               lane_hit;
    logic               is_self;

    for (genvar n = 0; n < TLIST_W; n++) begin : g_lane
        always_comb begin
            lane_sel[n] = req_i.tlist[n] && (core_i.a0[LANE_W-1:0] == LANE_W'(n));
        end
    end

    always_comb begin
        upper_eq = (req_i.aff3 == core_i.a3) && (req_i.aff2 == core_i.a2) &&
                   (req_i.aff1 == core_i.a1);
        group_eq = (core_i.a0[AFF_W-1:LANE_W] == eff_rs_i);
        lane_hit = |lane_sel;
        is_self  = (src_i == core_i);
        if (req_i.bcast) begin
            hit_o = !is_self;
        end else begin
            hit_o = !drop_i && upper_eq && group_eq && lane_hit;
        end
    end
endmodule

// File: rtl/sgi_target_decoder.sv
module sgi_target_decoder
    import sgi_rx_pkg::*;
#(
    parameter bit DROP_ON_RS_CONFLICT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [WORD_W-1:0]   req_word,
    input  logic [CORE_W-1:0]   core_aff,
    input  logic [CORE_W-1:0]   src_aff,
    input  logic                cpuif_rss,
    input  logic                dist_rss,
    output logic                pend_pulse,
    output logic [ID_W-1:0]     pend_id,
    output logic [STATUS_W-1:0] cpuif_ctl_status,
    output logic [STATUS_W-1:0] dist_type_status
);
    sgi_req_t        req;
    logic [RS_W-1:0] eff_rs;
    logic            drop;
    logic            hit;
    core_aff_t       core_s;
    core_aff_t       src_s;

    always_comb begin
        core_s = core_aff_t'(core_aff);
        src_s  = core_aff_t'(src_aff);
    end

    sgi_field_extract u_extract (
        .word_i (req_word),
        .req_o  (req)
    );

    sgi_rs_resolve #(
        .DROP_ON_RS_CONFLICT (DROP_ON_RS_CONFLICT)
    ) u_resolve (
        .cpuif_rss_i (cpuif_rss),
        .dist_rss_i  (dist_rss),
        .rs_field_i  (req.rs),
        .eff_rs_o    (eff_rs),
        .drop_o      (drop)
    );

    sgi_target_match u_match (
        .req_i    (req),
        .eff_rs_i (eff_rs),
        .drop_i   (drop),
        .core_i   (core_s),
        .src_i    (src_s),
        .hit_o    (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_pulse <= 1'b0;
            pend_id    <= '0;
        end else begin
            pend_pulse <= req_valid && hit;
            if (req_valid && hit) begin
                pend_id <= req.id;
            end
        end
    end

    always_comb begin
        cpuif_ctl_status = status_word(cpuif_rss, CPUIF_RSS_BIT);
        dist_type_status = status_word(dist_rss, DIST_RSS_BIT);
    end
endmodule

// File: rtl/sgi_target_decoder_chk.sv
module sgi_target_decoder_chk
    import sgi_rx_pkg::*;
#(
    parameter bit DROP_ON_RS_CONFLICT = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [WORD_W-1:0]   req_word,
    input logic [CORE_W-1:0]   core_aff,
    input logic [CORE_W-1:0]   src_aff,
    input logic                cpuif_rss,
    input logic                dist_rss,
    input logic                pend_pulse,
    input logic [ID_W-1:0]     pend_id,
    input logic [STATUS_W-1:0] cpuif_ctl_status,
    input logic [STATUS_W-1:0] dist_type_status
);
    // R8
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !pend_pulse);

    // R2
    pulse_id_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!pend_pulse || pend_id == $past(req_word[ID_LSB +: ID_W])));

    // R4
    high_core_unreachable_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cpuif_rss && !req_word[MODE_BIT] &&
         core_aff[AFF_W-1:LANE_W] != '0) |=> !pend_pulse);

    // R7
    bcast_self_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_word[MODE_BIT] && src_aff == core_aff) |=> !pend_pulse);

    // R7
    bcast_other_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_word[MODE_BIT] && src_aff != core_aff) |=> pend_pulse);

    generate
        if (DROP_ON_RS_CONFLICT) begin : g_drop_chk
            // R6
            rs_conflict_drop_chk: assert property (@(posedge clk) disable iff (rst)
                (req_valid && !req_word[MODE_BIT] && cpuif_rss && !dist_rss &&
                 req_word[RS_LSB +: RS_W] != '0) |=> !pend_pulse);
        end
    endgenerate

    // R9
    always_comb begin
        status_bits_chk: assert (cpuif_ctl_status == (STATUS_W'(cpuif_rss) << CPUIF_RSS_BIT) &&
                                 dist_type_status == (STATUS_W'(dist_rss) << DIST_RSS_BIT));
    end
endmodule

bind sgi_target_decoder sgi_target_decoder_chk #(
    .DROP_ON_RS_CONFLICT (DROP_ON_RS_CONFLICT)
) u_chk (.*);

// File: tb/sim_sgi_target_decoder.sv
module sim_sgi_target_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_word = '0;
    logic [31:0] core_aff = '0;
    logic [31:0] src_aff = '0;
    logic        cpuif_rss = 1'b0;
    logic        dist_rss = 1'b0;
    logic        p0, p1;
    logic [3:0]  id0, id1;
    logic [31:0] cs0, ds0, cs1, ds1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sgi_target_decoder #(.DROP_ON_RS_CONFLICT(1'b1)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_word(req_word),
        .core_aff(core_aff), .src_aff(src_aff), .cpuif_rss(cpuif_rss),
        .dist_rss(dist_rss), .pend_pulse(p0), .pend_id(id0),
        .cpuif_ctl_status(cs0), .dist_type_status(ds0));

    sgi_target_decoder #(.DROP_ON_RS_CONFLICT(1'b0)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_word(req_word),
        .core_aff(core_aff), .src_aff(src_aff), .cpuif_rss(cpuif_rss),
        .dist_rss(dist_rss), .pend_pulse(p1), .pend_id(id1),
        .cpuif_ctl_status(cs1), .dist_type_status(ds1));

    function automatic logic [63:0] mk(input logic [7:0] a3, input logic [7:0] a2,
                                       input logic [7:0] a1, input logic [3:0] id,
                                       input logic [3:0] rs, input logic b,
                                       input logic [15:0] tl);
        logic [63:0] w;
        w = '0;
        w[15:0] = tl; w[23:16] = a1; w[27:24] = id; w[39:32] = a2;
        w[40] = b; w[47:44] = rs; w[55:48] = a3;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one request, sampled on the negedge after the capturing posedge
    task automatic send(input logic [63:0] w);
        @(negedge clk);
        req_word = w;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R8 reset pulse", 32'(p0), 0);
        chk("R8 reset id", 32'(id0), 0);
        chk("R9 status zero cpuif", cs0, 0);
        chk("R9 status zero dist", ds0, 0);
    endtask

    task automatic t_status;
        @(negedge clk);
        cpuif_rss = 1; dist_rss = 1;
        #1;
        chk("R9 cpuif bit18", cs0, 32'h0004_0000);
        chk("R9 dist bit26", ds0, 32'h0400_0000);
        cpuif_rss = 1; dist_rss = 0;
        #1;
        chk("R9 dist cleared", ds0, 0);
        chk("R9 cpuif set", cs0, 32'h0004_0000);
    endtask

    task automatic t_basic;
        cpuif_rss = 0; dist_rss = 0;
        core_aff = 32'h0302_0105; src_aff = 32'h0302_0100;
        send(mk(8'h03, 8'h02, 8'h01, 4'h9, 4'h0, 1'b0, 16'h0020));
        chk("R2 R1 directed hit", 32'(p0), 1);
        chk("R2 hit id", 32'(id0), 9);
        send(mk(8'h03, 8'h02, 8'h01, 4'h4, 4'h0, 1'b0, 16'hFFDF));
        chk("R2 other lanes only", 32'(p0), 0);
        chk("R2 id held", 32'(id0), 9);
    endtask

    task automatic t_affmis;
        send(mk(8'h07, 8'h02, 8'h01, 4'h1, 4'h0, 1'b0, 16'hFFFF));
        chk("R3 aff3 mismatch", 32'(p0), 0);
        send(mk(8'h03, 8'h06, 8'h01, 4'h1, 4'h0, 1'b0, 16'hFFFF));
        chk("R3 aff2 mismatch", 32'(p0), 0);
        send(mk(8'h03, 8'h02, 8'h09, 4'h1, 4'h0, 1'b0, 16'hFFFF));
        chk("R3 aff1 mismatch", 32'(p0), 0);
    endtask

    task automatic t_rs_off;
        cpuif_rss = 0; dist_rss = 1;
        core_aff = 32'h0302_0105;
        send(mk(8'h03, 8'h02, 8'h01, 4'h2, 4'h7, 1'b0, 16'h0020));
        chk("R4 rs treated as zero", 32'(p0), 1);
        core_aff = 32'h0302_0125;
        send(mk(8'h03, 8'h02, 8'h01, 4'h2, 4'h2, 1'b0, 16'h0020));
        chk("R4 high core unreachable", 32'(p0), 0);
    endtask

    task automatic t_rs_on;
        cpuif_rss = 1; dist_rss = 1;
        core_aff = 32'h0302_0125;
        send(mk(8'h03, 8'h02, 8'h01, 4'h3, 4'h2, 1'b0, 16'h0020));
        chk("R5 group 2 lane 5", 32'(p0), 1);
        chk("R5 id", 32'(id0), 3);
        send(mk(8'h03, 8'h02, 8'h01, 4'h3, 4'h3, 1'b0, 16'h0020));
        chk("R5 wrong group", 32'(p0), 0);
        core_aff = 32'h0302_01FF;
        send(mk(8'h03, 8'h02, 8'h01, 4'hE, 4'hF, 1'b0, 16'h8000));
        chk("R5 core 255", 32'(p0), 1);
    endtask

    task automatic t_conflict;
        cpuif_rss = 1; dist_rss = 0;
        core_aff = 32'h0302_0105;
        send(mk(8'h03, 8'h02, 8'h01, 4'h6, 4'h1, 1'b0, 16'h0020));
        chk("R6 drop variant", 32'(p0), 0);
        chk("R6 force variant", 32'(p1), 1);
        chk("R6 force id", 32'(id1), 6);
        core_aff = 32'h0302_0115;
        send(mk(8'h03, 8'h02, 8'h01, 4'h6, 4'h1, 1'b0, 16'h0020));
        chk("R6 drop variant group1", 32'(p0), 0);
        chk("R6 force variant group1", 32'(p1), 0);
        core_aff = 32'h0302_0105;
        send(mk(8'h03, 8'h02, 8'h01, 4'h6, 4'h0, 1'b0, 16'h0020));
        chk("R6 zero rs drop variant", 32'(p0), 1);
    endtask

    task automatic t_bcast;
        cpuif_rss = 1; dist_rss = 0;
        core_aff = 32'h0302_0125; src_aff = 32'h0000_0000;
        send(mk(8'hAA, 8'hBB, 8'hCC, 4'hB, 4'h5, 1'b1, 16'h0000));
        chk("R7 bcast other", 32'(p0), 1);
        chk("R7 bcast id", 32'(id0), 11);
        src_aff = core_aff;
        send(mk(8'h03, 8'h02, 8'h01, 4'hC, 4'h2, 1'b1, 16'hFFFF));
        chk("R7 bcast self", 32'(p0), 0);
    endtask

    task automatic t_pulse;
        cpuif_rss = 0; dist_rss = 0;
        core_aff = 32'h0302_0101; src_aff = 32'h0;
        send(mk(8'h03, 8'h02, 8'h01, 4'hD, 4'h0, 1'b0, 16'h0002));
        chk("R8 pulse present", 32'(p0), 1);
        @(negedge clk);
        chk("R8 pulse one cycle", 32'(p0), 0);
        chk("R8 id kept", 32'(id0), 13);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_status();
        t_basic();
        t_affmis();
        t_rs_off();
        t_rs_on();
        t_conflict();
        t_bcast();
        t_pulse();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule